// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Two predictors run side by side. The first is a two-level local scheme: a small table holds one shift register of outcomes per branch, and that history, XORed with PC bits, selects a counter in a pattern table. The second is a global scheme: one shift register holds the outcomes of the most recent branches of any address, and it is XORed with PC bits to select a counter in its own pattern table. A third table of counters, indexed directly by PC bits, decides for each branch which of the two predictors to believe.

The prediction port is purely combinational. A fetch stage places a branch PC on it and reads a one-bit guess in the same cycle. The training port is used once a branch resolves. It takes the branch PC and the real outcome, and on the next rising clock edge it updates both pattern counters, the selector where the two predictors disagreed, and both histories. Training requests must arrive in program order.

Top module: `tbp_predictor`

## Requirements
- R1: While `rst` is high at a rising edge, every pattern counter and every selector counter is set to 1 and every history is cleared. After reset, `pred_taken` is 0 for every PC.
- R2: A counter is 2 bits wide and saturates. When trained taken it becomes min(3, value+1). When trained not-taken it becomes max(0, value-1).
- R3: A counter votes taken when its value is 2 or 3, and not-taken when its value is 0 or 1.
- R4: The local history entry is selected by PC[LHT_IDX_W+1:2]. The local pattern counter is selected by that entry XORed with PC[HIST_W+1:2].
- R5: The global pattern counter is selected by the global history register XORed with PC[HIST_W+1:2].
- R6: The selector counter is selected by PC[SEL_IDX_W+1:2]. A selector value of 2 or 3 passes the global vote to `pred_taken`, and a value of 0 or 1 passes the local vote. When the two votes agree, `pred_taken` equals that common vote.
- R7: A training request updates the selector only when the local and global votes for `upd_pc` differ. In that case the selector moves up (towards global) if the global vote matched `upd_taken`, and moves down otherwise.
- R8: On each training request, the global history and the addressed local history entry shift left by one bit. The new least significant bit is 1 for taken and 0 for not-taken. All votes used for that training are read from the state as it was before the edge.
- R9: `pred_taken` depends on `pred_pc` within the same cycle and shows every training applied at earlier edges. An edge with `upd_valid` low changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pred_pc | input | PC_W | PC of the branch to predict |
| pred_taken | output | 1 | Combinational taken guess for `pred_pc` |
| upd_valid | input | 1 | Training request present this cycle |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The hardest behaviour to reach from the ports is a selector changing value. A selector only moves when the local and global votes differ, and both votes are hidden behind histories that shift on every training request. The bench therefore uses a reduced configuration (4-bit histories, 4 local history entries, 8 selectors). In that configuration, loop-shaped patterns, pairs of branches with correlated outcomes, and long random streams over a narrow PC range drive the two predictors into disagreement many times. An arithmetic model runs in step with the design, and the bench compares `pred_taken` against it on every cycle.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

    typedef logic [1:0] ctr2_t;

    localparam ctr2_t CTR_INIT = 2'd1;

    typedef enum logic {
        PICK_LOCAL  = 1'b0,
        PICK_GLOBAL = 1'b1
    } pick_e;

    typedef struct packed {
        logic  loc;
        logic  glb;
        pick_e pick;
    } vote_t;

    function automatic ctr2_t ctr_train(ctr2_t c, logic dir);
        ctr2_t r;
        if (dir) r = (c == 2'd3) ? 2'd3 : c + 2'd1;
        else     r = (c == 2'd0) ? 2'd0 : c - 2'd1;
        return r;
    endfunction

    function automatic logic ctr_dir(ctr2_t c);
        return c[1];
    endfunction

endpackage

// File: rtl/tbp_ctr_table.sv
module tbp_ctr_table
    import tbp_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr2_t            rd_val,
    input  logic [IDX_W-1:0] tr_idx,
    output ctr2_t            tr_val,
    input  logic             tr_en,
    input  logic             tr_dir
);
    localparam int DEPTH = 1 << IDX_W;

    ctr2_t mem [DEPTH];

    assign rd_val = mem[rd_idx];
    assign tr_val = mem[tr_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_INIT;
        end else if (tr_en) begin
            mem[tr_idx] <= ctr_train(mem[tr_idx], tr_dir);
        end
    end
endmodule

// File: rtl/tbp_hist_table.sv
module tbp_hist_table #(
    parameter int IDX_W  = 6,
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [HIST_W-1:0] rd_hist,
    input  logic [IDX_W-1:0]  sh_idx,
    output logic [HIST_W-1:0] sh_hist,
    input  logic              sh_en,
    input  logic              sh_bit
);
    localparam int DEPTH = 1 << IDX_W;

    logic [HIST_W-1:0] hist [DEPTH];

    assign rd_hist = hist[rd_idx];
    assign sh_hist = hist[sh_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
        end else if (sh_en) begin
            hist[sh_idx] <= {hist[sh_idx][HIST_W-2:0], sh_bit};
        end
    end
endmodule

// File: rtl/tbp_predictor.sv
module tbp_predictor
    import tbp_pkg::*;
#(
    parameter int PC_W      = 32,
    parameter int LHT_IDX_W = 6,
    parameter int HIST_W    = 10,
    parameter int SEL_IDX_W = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);
    localparam int N_COMP = 2;   // 0: local, 1: global
    localparam int C_LOC  = 0;
    localparam int C_GLB  = 1;

    // PC fields above the word offset
    logic [HIST_W-1:0]    p_field, u_field;
    logic [LHT_IDX_W-1:0] p_lidx,  u_lidx;
    logic [SEL_IDX_W-1:0] p_sidx,  u_sidx;

    assign p_field = pred_pc[HIST_W+1:2];
    assign u_field = upd_pc[HIST_W+1:2];
    assign p_lidx  = pred_pc[LHT_IDX_W+1:2];
    assign u_lidx  = upd_pc[LHT_IDX_W+1:2];
    assign p_sidx  = pred_pc[SEL_IDX_W+1:2];
    assign u_sidx  = upd_pc[SEL_IDX_W+1:2];

    // Histories
    logic [HIST_W-1:0] ghist_q;
    logic [HIST_W-1:0] p_lhist, u_lhist;

    always_ff @(posedge clk) begin
        if (rst)            ghist_q <= '0;
        else if (upd_valid) ghist_q <= {ghist_q[HIST_W-2:0], upd_taken};
    end

    tbp_hist_table #(.IDX_W(LHT_IDX_W), .HIST_W(HIST_W)) lht_i (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (p_lidx),
        .rd_hist (p_lhist),
        .sh_idx  (u_lidx),
        .sh_hist (u_lhist),
        .sh_en   (upd_valid),
        .sh_bit  (upd_taken)
    );

    // Pattern tables, one per component
    logic [HIST_W-1:0] p_idx [N_COMP];
    logic [HIST_W-1:0] u_idx [N_COMP];
    ctr2_t             p_val [N_COMP];
    ctr2_t             u_val [N_COMP];

    assign p_idx[C_LOC] = p_lhist ^ p_field;
    assign u_idx[C_LOC] = u_lhist ^ u_field;
    assign p_idx[C_GLB] = ghist_q ^ p_field;
    assign u_idx[C_GLB] = ghist_q ^ u_field;

    for (genvar g = 0; g < N_COMP; g++) begin : g_pht
        tbp_ctr_table #(.IDX_W(HIST_W)) pht_i (
            .clk    (clk),
            .rst    (rst),
            .rd_idx (p_idx[g]),
            .rd_val (p_val[g]),
            .tr_idx (u_idx[g]),
            .tr_val (u_val[g]),
            .tr_en  (upd_valid),
            .tr_dir (upd_taken)
        );
    end

    // Selector
    ctr2_t p_sval, u_sval;
    vote_t p_vote, u_vote;
    logic  sel_en, sel_dir;

    assign p_vote.loc  = ctr_dir(p_val[C_LOC]);
    assign p_vote.glb  = ctr_dir(p_val[C_GLB]);
    assign p_vote.pick = ctr_dir(p_sval) ? PICK_GLOBAL : PICK_LOCAL;
    assign u_vote.loc  = ctr_dir(u_val[C_LOC]);
    assign u_vote.glb  = ctr_dir(u_val[C_GLB]);
    assign u_vote.pick = ctr_dir(u_sval) ? PICK_GLOBAL : PICK_LOCAL;

    assign sel_en  = upd_valid && (u_vote.loc != u_vote.glb);
    assign sel_dir = (u_vote.glb == upd_taken);

    tbp_ctr_table #(.IDX_W(SEL_IDX_W)) sel_i (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (p_sidx),
        .rd_val (p_sval),
        .tr_idx (u_sidx),
        .tr_val (u_sval),
        .tr_en  (sel_en),
        .tr_dir (sel_dir)
    );

    assign pred_taken = (p_vote.pick == PICK_GLOBAL) ? p_vote.glb : p_vote.loc;

endmodule

// File: rtl/tbp_predictor_chk.sv
module tbp_predictor_chk #(
    parameter int HIST_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              upd_valid,
    input logic              upd_taken,
    input logic              pred_taken,
    input logic [HIST_W-1:0] ghist,
    input logic              p_loc,
    input logic              p_glb
);
    // R1: reset clears the global history
    a_r1_hist_clear: assert property (@(posedge clk)
        rst |=> (ghist == '0));

    // R8: training shifts the outcome into the global history
    a_r8_ghist_shift: assert property (@(posedge clk) disable iff (rst)
        upd_valid |=> (ghist == {$past(ghist[HIST_W-2:0]), $past(upd_taken)}));

    // R9: idle edge leaves history untouched
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !upd_valid |=> $stable(ghist));

    // R6: agreeing votes pass through whatever the selector says
    a_r6_agree_pass: assert property (@(posedge clk) disable iff (rst)
        (p_loc == p_glb) |-> (pred_taken == p_loc));
endmodule

bind tbp_predictor tbp_predictor_chk #(.HIST_W(HIST_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .upd_valid  (upd_valid),
    .upd_taken  (upd_taken),
    .pred_taken (pred_taken),
    .ghist      (ghist_q),
    .p_loc      (p_vote.loc),
    .p_glb      (p_vote.glb)
);

// File: tb/tbp_predictor_tb_top.sv
`timescale 1ns/1ps
module tbp_predictor_tb_top;
    localparam int PC_W = 16;
    localparam int LW   = 2;   // local history table index bits
    localparam int HW   = 4;   // history / pattern index bits
    localparam int SW   = 3;   // selector index bits

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [PC_W-1:0] pred_pc = '0;
    logic            pred_taken;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic            upd_taken = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;   // 50 MHz

    tbp_predictor #(.PC_W(PC_W), .LHT_IDX_W(LW), .HIST_W(HW), .SEL_IDX_W(SW)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .pred_pc    (pred_pc),
        .pred_taken (pred_taken),
        .upd_valid  (upd_valid),
        .upd_pc     (upd_pc),
        .upd_taken  (upd_taken)
    );

    // Arithmetic reference state
    int m_lh  [1<<LW];
    int m_lc  [1<<HW];
    int m_gc  [1<<HW];
    int m_sc  [1<<SW];
    int m_gh;

    function automatic int fld(int pc);  return (pc >> 2) % (1<<HW); endfunction
    function automatic int lsel(int pc); return (pc >> 2) % (1<<LW); endfunction
    function automatic int ssel(int pc); return (pc >> 2) % (1<<SW); endfunction
    function automatic int vote(int c);  return (c >= 2) ? 1 : 0; endfunction
    function automatic int step(int c, int t);
        if (t != 0) return (c < 3) ? c + 1 : 3;
        return (c > 0) ? c - 1 : 0;
    endfunction

    function automatic void m_reset();
        for (int i = 0; i < (1<<LW); i++) m_lh[i] = 0;
        for (int i = 0; i < (1<<HW); i++) begin m_lc[i] = 1; m_gc[i] = 1; end
        for (int i = 0; i < (1<<SW); i++) m_sc[i] = 1;
        m_gh = 0;
    endfunction

    function automatic int m_pred(int pc);
        int lv, gv;
        lv = vote(m_lc[m_lh[lsel(pc)] ^ fld(pc)]);
        gv = vote(m_gc[m_gh ^ fld(pc)]);
        return (m_sc[ssel(pc)] >= 2) ? gv : lv;
    endfunction

    function automatic void m_train(int pc, int t);
        int li, gi, lv, gv, mask;
        mask = (1<<HW) - 1;
        li = m_lh[lsel(pc)] ^ fld(pc);
        gi = m_gh ^ fld(pc);
        lv = vote(m_lc[li]);
        gv = vote(m_gc[gi]);
        if (lv != gv) m_sc[ssel(pc)] = step(m_sc[ssel(pc)], (gv == t) ? 1 : 0);
        m_lc[li] = step(m_lc[li], t);
        m_gc[gi] = step(m_gc[gi], t);
        m_lh[lsel(pc)] = ((m_lh[lsel(pc)] << 1) | t) & mask;
        m_gh = ((m_gh << 1) | t) & mask;
    endfunction

    task automatic check(input int exp, input string req);
        n_cmp++;
        if (int'(pred_taken) != exp) begin
            n_bad++;
            $display("FAIL %s pc=%0h actual=%0d expected=%0d", req, pred_pc, pred_taken, exp);
        end
    endtask

    // One cycle: drive at falling edge, compare, apply model, cross rising edge
    task automatic cyc(input int ppc, input bit v, input int upc, input int t, input string req);
        @(negedge clk);
        pred_pc   = ppc[PC_W-1:0];
        upd_valid = v;
        upd_pc    = upc[PC_W-1:0];
        upd_taken = t[0];
        #2;
        check(m_pred(ppc), req);
        if (v) m_train(upc, t);
        @(posedge clk);
    endtask

    // Predict/train same branch
    task automatic br(input int pc, input int t, input string req);
        cyc(pc, 1'b1, pc, t, req);
    endtask

    initial begin
        int a;
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: every PC predicts not-taken after reset
        for (int pc = 0; pc < 256; pc += 4) begin
            cyc(pc, 1'b0, 0, 0, "R1");
            if (pred_taken !== 1'b0) begin
                n_bad++;
                $display("FAIL R1 pc=%0h actual=%0d expected=0", pc, pred_taken);
            end
        end

        // R2 R8: single taken training, then neighbouring PCs
        cyc(0, 1'b1, 0, 1, "R2 R8");
        for (int pc = 0; pc < 64; pc += 4) cyc(pc, 1'b0, 0, 0, "R2 R4 R5 R8");

        // R2 R3: long taken run saturates, then not-taken run drains
        for (int i = 0; i < 12; i++) br(32'h40, 1, "R2 R3");
        for (int i = 0; i < 12; i++) br(32'h40, 0, "R2 R3");

        // R4 R7: loop shape T T T N on one branch
        for (int i = 0; i < 200; i++) br(32'h24, (i % 4 == 3) ? 0 : 1, "R4 R6 R7");

        // R5 R6 R7: second branch copies the first one's outcome
        for (int i = 0; i < 300; i++) begin
            a = $urandom % 2;
            br(32'h8, a, "R5 R6 R7");
            br(32'h1c, a, "R5 R6 R7");
        end

        // R6 R7 R8: random stream over a narrow PC range, independent predict PC
        for (int i = 0; i < 3000; i++)
            cyc(($urandom % 64) * 4, 1'b1, ($urandom % 16) * 4, $urandom % 2, "R6 R7 R8");

        // R9: idle edges with garbage on the training port change nothing
        for (int i = 0; i < 64; i++)
            cyc(i * 4, 1'b0, $urandom % 256, $urandom % 2, "R9");
        for (int pc = 0; pc < 256; pc += 4) cyc(pc, 1'b0, 0, 0, "R9");

        // R1: second reset mid-stream restores initial state
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_reset();
        for (int pc = 0; pc < 256; pc += 4) cyc(pc, 1'b0, 0, 0, "R1");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule